// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a register file in which every subroutine nesting level sees its own window of eight logical registers. Neighbouring windows share four physical registers. The upper half of the caller's window becomes the lower half of the callee's window, so arguments and results pass between the two levels without any memory traffic.

The file has two combinational read ports and one write port. All three ports take a logical register number, and that number is resolved through the current window pointer. A call strobe moves the pointer one window deeper and a return strobe moves it one window back. Each move takes effect on the next clock edge. A move that would leave the physical file is refused and reported on a one-cycle status flag. Spilling windows to memory is left to the surrounding logic.

Top module: `regwin_file`

## Requirements
- R1: A synchronous active-high reset sets the window pointer to 0 and clears both status flags. Register contents are not cleared.
- R2: A write with `wr_en` high stores `wr_data` at the clock edge into physical register `win_ptr*4 + wr_idx`. A later read of the same logical number in the same window returns that value.
- R3: A call (`call_i`=1, `ret_i`=0) while the pointer is below `NUM_WIN-1` raises the pointer by one at the next edge.
- R4: A return (`ret_i`=1, `call_i`=0) while the pointer is above 0 lowers the pointer by one at the next edge.
- R5: A call while the pointer is `NUM_WIN-1` leaves the pointer unchanged. `ovf_o` is 1 for exactly the following cycle.
- R6: A return while the pointer is 0 leaves the pointer unchanged. `unf_o` is 1 for exactly the following cycle.
- R7: After a call, the callee's logical registers 0 to 3 return the values that the caller held in its logical registers 4 to 7.
- R8: Writes made by a callee never change the caller's logical registers 0 to 3. After the return, the caller reads its old values.
- R9: When a read port and the write port resolve to the same physical register in one cycle, the read returns `wr_data` in that same cycle.
- R10: Call and return asserted together cancel each other. The pointer does not move and neither flag is raised.
- R11: A write issued in the same cycle as a call or return is resolved through the window that was current before the move.
- R12: The two read ports are independent. Each one returns the register selected by its own index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 3 | Logical register number, read port A |
| rd_a_data | output | 32 | Read data, port A (combinational) |
| rd_b_idx | input | 3 | Logical register number, read port B |
| rd_b_data | output | 32 | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Logical register number for the write |
| wr_data | input | 32 | Write data |
| call_i | input | 1 | Move one window deeper |
| ret_i | input | 1 | Move one window back |
| win_ptr | output | 3 | Current window pointer |
| ovf_o | output | 1 | Refused call in the previous cycle |
| unf_o | output | 1 | Refused return in the previous cycle |

## Verification
The collision that matters is a write landing in the same cycle as a window move. A write that lands with a read to the same physical register is the other case. The bench provokes the first by issuing a write to logical register 6 on every call that descends through the file. It later reads that register back as logical 2 of the deeper window, which shows that the pre-move window was used. It provokes the second by reading and writing one index in one cycle on both ports. A behavioural model, a plain array indexed by pointer arithmetic, predicts every read value, the pointer and both flags, and these predictions are compared every cycle.

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int DATA_W   = 32,
  parameter int NUM_WIN  = 8,
  parameter int WIN_REGS = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(WIN_REGS)-1:0] rd_a_idx,
  output logic [DATA_W-1:0]           rd_a_data,
  input  logic [$clog2(WIN_REGS)-1:0] rd_b_idx,
  output logic [DATA_W-1:0]           rd_b_data,
  input  logic                        wr_en,
  input  logic [$clog2(WIN_REGS)-1:0] wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        call_i,
  input  logic                        ret_i,
  output logic [$clog2(NUM_WIN)-1:0]  win_ptr,
  output logic                        ovf_o,
  output logic                        unf_o
);
  localparam int HALF   = WIN_REGS / 2;
  localparam int PHYS   = HALF * NUM_WIN + HALF;
  localparam int PIDX_W = $clog2(PHYS);
  localparam int LIDX_W = $clog2(WIN_REGS);
  localparam int PTR_W  = $clog2(NUM_WIN);

  logic [DATA_W-1:0] regs [PHYS];
  logic [PIDX_W-1:0] wr_p, ra_p, rb_p;

  function automatic logic [PIDX_W-1:0] to_phys(input logic [PTR_W-1:0] p,
                                                input logic [LIDX_W-1:0] i);
    return PIDX_W'(p) * PIDX_W'(HALF) + PIDX_W'(i);
  endfunction

  assign wr_p = to_phys(win_ptr, wr_idx);
  assign ra_p = to_phys(win_ptr, rd_a_idx);
  assign rb_p = to_phys(win_ptr, rd_b_idx);

  always_ff @(posedge clk)
    if (wr_en) regs[wr_p] <= wr_data;

  assign rd_a_data = (wr_en && wr_p == ra_p) ? wr_data : regs[ra_p];
  assign rd_b_data = (wr_en && wr_p == rb_p) ? wr_data : regs[rb_p];

  logic do_call, do_ret, at_top, at_bot;
  assign do_call = call_i & ~ret_i;
  assign do_ret  = ret_i & ~call_i;
  assign at_top  = (win_ptr == PTR_W'(NUM_WIN - 1));
  assign at_bot  = (win_ptr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_ptr <= '0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
    end else begin
      ovf_o <= do_call & at_top;
      unf_o <= do_ret & at_bot;
      if (do_call && !at_top)     win_ptr <= win_ptr + 1'b1;
      else if (do_ret && !at_bot) win_ptr <= win_ptr - 1'b1;
    end
  end

  p_store_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> regs[$past(wr_p)] == $past(wr_data));
  p_call_r3: assert property (@(posedge clk) disable iff (rst)
    (call_i && !ret_i && !at_top) |=> win_ptr == $past(win_ptr) + 1'b1);
  p_ret_r4: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && !at_bot) |=> win_ptr == $past(win_ptr) - 1'b1);
  p_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (call_i && !ret_i && at_top) |=> ovf_o && $stable(win_ptr));
  p_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i && at_bot) |=> unf_o && $stable(win_ptr));
  p_cancel_r10: assert property (@(posedge clk) disable iff (rst)
    (call_i && ret_i) |=> $stable(win_ptr) && !ovf_o && !unf_o);
endmodule

// File: tb/sim_regwin_file.sv
module sim_regwin_file;
  localparam int NW = 8;
  localparam int PH = 4 * NW + 4;

  logic clk = 0, rst = 1;
  logic [2:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0;
  logic wr_en = 0, call_i = 0, ret_i = 0;
  logic [2:0] win_ptr;
  logic ovf_o, unf_o;

  always #10 clk = ~clk;

  regwin_file u0 (.clk(clk), .rst(rst), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .call_i(call_i), .ret_i(ret_i), .win_ptr(win_ptr),
    .ovf_o(ovf_o), .unf_o(unf_o));

  int checks = 0, failures = 0;
  logic [31:0] mem [PH];
  bit vld [PH];
  int mptr = 0;
  bit movf = 0, munf = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit c, bit r, bit we, int wi, logic [31:0] wd,
                      int ra, int rb);
    int wp, pa, pb;
    @(negedge clk);
    call_i = c; ret_i = r; wr_en = we; wr_idx = 3'(wi); wr_data = wd;
    rd_a_idx = 3'(ra); rd_b_idx = 3'(rb);
    #2;
    chk(tag, "win_ptr", win_ptr, mptr);
    chk(tag, "ovf_o", ovf_o, movf);
    chk(tag, "unf_o", unf_o, munf);
    wp = mptr * 4 + wi; pa = mptr * 4 + ra; pb = mptr * 4 + rb;
    if (we && wp == pa) chk(tag, "rd_a bypass", rd_a_data, wd);
    else if (vld[pa]) chk(tag, "rd_a", rd_a_data, mem[pa]);
    if (we && wp == pb) chk(tag, "rd_b bypass", rd_b_data, wd);
    else if (vld[pb]) chk(tag, "rd_b", rd_b_data, mem[pb]);
    @(posedge clk);
    if (we) begin mem[wp] = wd; vld[wp] = 1; end
    movf = c && !r && mptr == NW - 1;
    munf = r && !c && mptr == 0;
    if (c && !r && mptr < NW - 1) mptr++;
    else if (r && !c && mptr > 0) mptr--;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #2;
    chk("R1", "win_ptr after reset", win_ptr, 0);
    chk("R1", "ovf_o after reset", ovf_o, 0);
    chk("R1", "unf_o after reset", unf_o, 0);
    for (int i = 0; i < 8; i++) step("R2", 0, 0, 1, i, 32'hA000_0000 + i, i, (i + 7) % 8);
    for (int i = 0; i < 8; i++) step("R12", 0, 0, 0, 0, 0, i, 7 - i);
    step("R3", 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R7", 0, 0, 0, 0, 0, i, i + 4);
    for (int i = 0; i < 8; i++) step("R8", 0, 0, 1, i, 32'hB000_0000 + i, i, i);
    step("R4", 0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step("R8", 0, 0, 0, 0, 0, i, 3 - (i % 4));
    step("R6", 0, 1, 0, 0, 0, 0, 1);
    step("R6", 0, 0, 0, 0, 0, 0, 1);
    step("R10", 1, 1, 0, 0, 0, 2, 3);
    step("R10", 0, 0, 0, 0, 0, 2, 3);
    for (int l = 0; l < NW - 1; l++) begin
      step("R11", 1, 0, 1, 6, 32'hC000_0000 + l, 4, 6);
      step("R11", 0, 0, 0, 0, 0, 2, 6);
    end
    step("R5", 1, 0, 0, 0, 0, 0, 1);
    step("R5", 0, 0, 0, 0, 0, 2, 3);
    step("R10", 1, 1, 0, 0, 0, 2, 3);
    step("R9", 0, 0, 1, 3, 32'hD00D_0003, 3, 3);
    step("R9", 0, 0, 1, 5, 32'hD00D_0005, 5, 1);
    step("R9", 0, 0, 0, 0, 0, 3, 5);
    for (int l = 0; l < NW - 1; l++) begin
      step("R11", 0, 1, 1, 1, 32'hE000_0000 + l, 1, 5);
      step("R4", 0, 0, 0, 0, 0, 5, 2);
    end
    step("R6", 0, 1, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 4, 5);
    for (int i = 0; i < 8; i++) step("R2", 0, 0, 0, 0, 0, i, i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule